// File: doc/BRIEF.md
# TDM Channel Slot Selector

This block follows the channel slots of a time-division multiplexed serial frame. A serializer next to it does the bit shifting. When a frame sync is seen on a serial clock tick, the selector waits a programmed number of serial clocks. It then counts consecutive channel slots, each one word long. For every slot it reports the channel index and says whether the serializer should move data in that slot. That answer comes from a 128-bit channel map and a window of channels set by an offset and a size.

With multichannel operation switched off, the selector does not gate anything: the slot enable stays high, so the serializer works in plain framed mode. Every input is sampled on system clock edges. The serial clock is represented by a one-cycle enable, `sclk_en`, and all slot timing advances only on those ticks.

Top module: `tdm_slot_selector`

## Requirements
- R1: While `mc_en` is low, one clock later `slot_en` is 1, `ch_busy` is 0 and `ch_idx` is 0, whatever `fs_det` does.
- R2: A frame sync on tick 0 with `frame_dly` = d leaves `ch_busy` low after ticks 0 to d-1. After tick d the first slot (channel 0) is serviced. With d = 0, channel 0 starts right after the sync tick.
- R3: Each slot lasts `word_len`+1 serial ticks. After tick t (with t ≥ d) `ch_idx` equals (t-d)/(`word_len`+1). Between two ticks of the same frame the index stays the same or rises by one.
- R4: Slots of channels whose index is below `win_off` never assert `slot_en`.
- R5: The last serviced channel is `win_off` + 8·(`win_size`+1) − 1, capped at 127. After that slot, and before the first frame sync after enabling, `ch_busy` and `slot_en` are 0 and `ch_idx` is 0 until the next sync.
- R6: For a serviced channel c with c ≥ `win_off`, `slot_en` equals `ch_map[c]` (bit c, LSB = channel 0) for the whole slot.
- R7: A frame sync in the middle of a frame restarts the delay count and sets the channel index back to 0. The timing that follows is the same as after a first sync.
- R8: While `rst` is high, `slot_en`, `ch_busy` and `ch_idx` are all 0 one clock later.
- R9: With `mc_en` high, the outputs `ch_idx` and `ch_busy` do not change on clock edges where `sclk_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_en | input | 1 | One-cycle serial clock tick |
| fs_det | input | 1 | Frame sync detected, qualified by `sclk_en` |
| mc_en | input | 1 | Multichannel operation enable |
| word_len | input | 5 | Slot length minus one, in serial ticks |
| frame_dly | input | 8 | Serial ticks from frame sync to the first slot |
| win_off | input | 7 | First channel that may carry data |
| win_size | input | 4 | Window size code; the window spans 8·(code+1) channels |
| ch_map | input | 128 | Per-channel select bitmap |
| slot_en | output | 1 | Registered slot enable for the serializer |
| ch_busy | output | 1 | A channel slot is being serviced |
| ch_idx | output | 7 | Index of the channel being serviced |

## Verification
On every clock the assertions check these properties: the pass-through value while multichannel operation is off, the quiet outputs between ticks, the index stepping by at most one, the silence of channels below the offset and the absence of activity during the frame delay. The exact tick on which each slot starts, where the window ends for different offsets and sizes (including the cap at channel 127), and whether `slot_en` follows the bitmap can only be shown by the bench. It runs whole frames with several configurations and compares each tick against a model built from the requirements. The same goes for restarting after a mid-frame sync.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DELAY = 2'd1,
    PH_SLOT  = 2'd2,
    PH_DONE  = 2'd3
  } phase_e;
endpackage

// File: rtl/tdm_frame_seq.sv
module tdm_frame_seq
  import tdm_slot_pkg::*;
#(
  parameter int NCH  = 128,
  parameter int CHW  = $clog2(NCH),
  parameter int WLW  = 5,
  parameter int DLYW = 8,
  parameter int WSW  = 4,
  parameter int GRP  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sclk_en,
  input  logic            fs_det,
  input  logic            run,
  input  logic [WLW-1:0]  word_len,
  input  logic [DLYW-1:0] frame_dly,
  input  logic [CHW-1:0]  win_off,
  input  logic [WSW-1:0]  win_size,
  output logic [CHW-1:0]  ch_q,
  output logic            busy_q,
  output logic [CHW-1:0]  nxt_ch,
  output logic            nxt_busy
);
  localparam int SW = CHW + 2;

  phase_e          ph_q, ph_n;
  logic [DLYW-1:0] dly_q, dly_n;
  logic [WLW-1:0]  bit_q, bit_n;
  logic [CHW-1:0]  ch_n;
  logic [SW-1:0]   span_end;
  logic [CHW-1:0]  last_ch;

  // last channel of the window, capped to the map size
  always_comb begin
    span_end = {2'b00, win_off} + (SW'(win_size) + SW'(1)) * SW'(GRP) - SW'(1);
    last_ch  = (span_end > SW'(NCH - 1)) ? CHW'(NCH - 1) : span_end[CHW-1:0];
  end

  always_comb begin
    ph_n  = ph_q;
    dly_n = dly_q;
    bit_n = bit_q;
    ch_n  = ch_q;
    if (!run) begin
      ph_n  = PH_IDLE;
      dly_n = '0;
      bit_n = '0;
      ch_n  = '0;
    end else if (sclk_en) begin
      if (fs_det) begin
        dly_n = frame_dly;
        bit_n = '0;
        ch_n  = '0;
        ph_n  = (frame_dly == '0) ? PH_SLOT : PH_DELAY;
      end else begin
        case (ph_q)
          PH_DELAY: begin
            if (dly_q <= DLYW'(1)) begin
              ph_n  = PH_SLOT;
              bit_n = '0;
              ch_n  = '0;
            end else begin
              dly_n = dly_q - DLYW'(1);
            end
          end
          PH_SLOT: begin
            if (bit_q == word_len) begin
              bit_n = '0;
              if (ch_q == last_ch) begin
                ph_n = PH_DONE;
                ch_n = '0;
              end else begin
                ch_n = ch_q + CHW'(1);
              end
            end else begin
              bit_n = bit_q + WLW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      dly_q <= '0;
      bit_q <= '0;
      ch_q  <= '0;
    end else begin
      ph_q  <= ph_n;
      dly_q <= dly_n;
      bit_q <= bit_n;
      ch_q  <= ch_n;
    end
  end

  assign busy_q   = (ph_q == PH_SLOT);
  assign nxt_ch   = ch_n;
  assign nxt_busy = (ph_n == PH_SLOT);
endmodule

// File: rtl/tdm_slot_lookup.sv
module tdm_slot_lookup #(
  parameter int NCH = 128,
  parameter int CHW = $clog2(NCH)
) (
  input  logic [CHW-1:0] ch,
  input  logic           busy,
  input  logic [CHW-1:0] win_off,
  input  logic [NCH-1:0] ch_map,
  output logic           hit
);
  assign hit = busy && (ch >= win_off) && ch_map[ch];
endmodule

// File: rtl/tdm_slot_selector.sv
module tdm_slot_selector #(
  parameter int NCH  = 128,
  parameter int WLW  = 5,
  parameter int DLYW = 8,
  parameter int WSW  = 4,
  parameter int GRP  = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sclk_en,
  input  logic            fs_det,
  input  logic            mc_en,
  input  logic [WLW-1:0]  word_len,
  input  logic [DLYW-1:0] frame_dly,
  input  logic [CHW-1:0]  win_off,
  input  logic [WSW-1:0]  win_size,
  input  logic [NCH-1:0]  ch_map,
  output logic            slot_en,
  output logic            ch_busy,
  output logic [CHW-1:0]  ch_idx
);
  logic [CHW-1:0] nxt_ch;
  logic           nxt_busy;
  logic           nxt_hit;
  logic           slot_en_q;

  tdm_frame_seq #(
    .NCH(NCH), .CHW(CHW), .WLW(WLW), .DLYW(DLYW), .WSW(WSW), .GRP(GRP)
  ) u_seq (
    .clk(clk), .rst(rst), .sclk_en(sclk_en), .fs_det(fs_det), .run(mc_en),
    .word_len(word_len), .frame_dly(frame_dly), .win_off(win_off),
    .win_size(win_size), .ch_q(ch_idx), .busy_q(ch_busy),
    .nxt_ch(nxt_ch), .nxt_busy(nxt_busy)
  );

  tdm_slot_lookup #(.NCH(NCH), .CHW(CHW)) u_lookup (
    .ch(nxt_ch), .busy(nxt_busy), .win_off(win_off), .ch_map(ch_map),
    .hit(nxt_hit)
  );

  // enable is registered from the next slot state so it lines up with ch_idx
  always_ff @(posedge clk) begin
    if (rst) slot_en_q <= 1'b0;
    else     slot_en_q <= mc_en ? nxt_hit : 1'b1;
  end

  assign slot_en = slot_en_q;
endmodule

// File: rtl/tdm_slot_selector_chk.sv
module tdm_slot_selector_chk #(
  parameter int CHW  = 7,
  parameter int DLYW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            sclk_en,
  input logic            fs_det,
  input logic            mc_en,
  input logic [DLYW-1:0] frame_dly,
  input logic [CHW-1:0]  win_off,
  input logic            slot_en,
  input logic            ch_busy,
  input logic [CHW-1:0]  ch_idx
);
  p_bypass_r1: assert property (@(posedge clk) disable iff (rst)
    !mc_en |=> (slot_en && !ch_busy && ch_idx == '0));

  p_delay_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(sclk_en && fs_det && mc_en && frame_dly != '0) && mc_en) |-> !ch_busy);

  p_idx_step_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(ch_busy) && ch_busy && $past(mc_en) && mc_en && !$past(fs_det))
      |-> (ch_idx == $past(ch_idx) || ch_idx == $past(ch_idx) + CHW'(1)));

  p_below_off_r4: assert property (@(posedge clk) disable iff (rst)
    (mc_en && $past(mc_en) && $stable(win_off) && ch_busy && ch_idx < win_off) |-> !slot_en);

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (mc_en && $past(mc_en) && !ch_busy) |-> !slot_en);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(!sclk_en) && $past(mc_en) && mc_en) |-> ($stable(ch_idx) && $stable(ch_busy)));
endmodule

bind tdm_slot_selector tdm_slot_selector_chk #(.CHW(CHW), .DLYW(DLYW)) u_chk (
  .clk(clk), .rst(rst), .sclk_en(sclk_en), .fs_det(fs_det), .mc_en(mc_en),
  .frame_dly(frame_dly), .win_off(win_off), .slot_en(slot_en),
  .ch_busy(ch_busy), .ch_idx(ch_idx)
);

// File: tb/tdm_slot_selector_tb.sv
`timescale 1ns/1ps
module tdm_slot_selector_tb;
  localparam int NCH = 128;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             sclk_en = 1'b0;
  logic             fs_det = 1'b0;
  logic             mc_en = 1'b0;
  logic [4:0]       word_len = '0;
  logic [7:0]       frame_dly = '0;
  logic [6:0]       win_off = '0;
  logic [3:0]       win_size = '0;
  logic [NCH-1:0]   ch_map = '0;
  logic             slot_en;
  logic             ch_busy;
  logic [6:0]       ch_idx;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tdm_slot_selector u_dut (
    .clk(clk), .rst(rst), .sclk_en(sclk_en), .fs_det(fs_det), .mc_en(mc_en),
    .word_len(word_len), .frame_dly(frame_dly), .win_off(win_off),
    .win_size(win_size), .ch_map(ch_map), .slot_en(slot_en),
    .ch_busy(ch_busy), .ch_idx(ch_idx)
  );

  // fields: last channel, seed, size code, offset, word_len, delay
  localparam logic [47:0] VEC [0:3] = '{
    {8'd7,   8'd1, 8'd0,  8'd0,   8'd3, 8'd0},
    {8'd19,  8'd2, 8'd1,  8'd4,   8'd1, 8'd3},
    {8'd127, 8'd3, 8'd15, 8'd120, 8'd0, 8'd1},
    {8'd9,   8'd5, 8'd0,  8'd2,   8'd7, 8'd5}
  };

  function automatic logic [NCH-1:0] mk_map(input int seed);
    logic [NCH-1:0] m;
    for (int i = 0; i < NCH; i++) m[i] = (((i * seed) + (i / 3)) % 5) < 2;
    return m;
  endfunction

  task automatic check(input string tag, input logic a_en, input logic a_busy,
                       input logic [6:0] a_idx, input logic e_en,
                       input logic e_busy, input logic [6:0] e_idx);
    checks++;
    if (a_en !== e_en || a_busy !== e_busy || a_idx !== e_idx) begin
      fails++;
      $display("FAIL %s: actual en=%b busy=%b idx=%0d expected en=%b busy=%b idx=%0d",
               tag, a_en, a_busy, a_idx, e_en, e_busy, e_idx);
    end
  endtask

  // one serial tick followed by one idle clock; the idle clock must not move state
  task automatic tick(input logic fs);
    logic s_busy;
    logic [6:0] s_idx;
    @(negedge clk);
    sclk_en = 1'b1;
    fs_det  = fs;
    @(negedge clk);
    sclk_en = 1'b0;
    fs_det  = 1'b0;
    s_busy = ch_busy;
    s_idx  = ch_idx;
    @(negedge clk);
    if (mc_en) check("R9 hold between ticks", 1'b0, ch_busy, ch_idx, 1'b0, s_busy, s_idx);
  endtask

  task automatic model(input int t, input int d, input int len, input int off,
                       input int last, input logic [NCH-1:0] m,
                       output logic e_en, output logic e_busy, output logic [6:0] e_idx);
    int c;
    e_en = 1'b0; e_busy = 1'b0; e_idx = '0;
    if (t >= d) begin
      c = (t - d) / len;
      if (c <= last) begin
        e_busy = 1'b1;
        e_idx  = 7'(c);
        e_en   = (c >= off) && m[c];
      end
    end
  endtask

  task automatic run_frame(input int d, input int wl, input int off, input int ws,
                           input int last, input logic [NCH-1:0] m,
                           input int nticks, input string tag);
    logic e_en, e_busy;
    logic [6:0] e_idx;
    frame_dly = 8'(d); word_len = 5'(wl); win_off = 7'(off);
    win_size = 4'(ws); ch_map = m;
    for (int t = 0; t <= nticks; t++) begin
      tick(t == 0);
      model(t, d, wl + 1, off, last, m, e_en, e_busy, e_idx);
      check(tag, slot_en, ch_busy, ch_idx, e_en, e_busy, e_idx);
    end
  endtask

  initial begin
    logic [47:0] v;
    int d, wl, off, ws, last;
    repeat (3) @(negedge clk);
    check("R8 reset outputs", slot_en, ch_busy, ch_idx, 1'b0, 1'b0, 7'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 bypass after reset", slot_en, ch_busy, ch_idx, 1'b1, 1'b0, 7'd0);
    for (int k = 0; k < 4; k++) begin
      tick(k[0]);
      check("R1 bypass with frame sync", slot_en, ch_busy, ch_idx, 1'b1, 1'b0, 7'd0);
    end

    mc_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R5 idle before first sync", slot_en, ch_busy, ch_idx, 1'b0, 1'b0, 7'd0);

    // table-driven frames covering R2 R3 R4 R5 R6
    for (int i = 0; i < 4; i++) begin
      v = VEC[i];
      d = int'(v[7:0]); wl = int'(v[15:8]); off = int'(v[23:16]);
      ws = int'(v[31:24]); last = int'(v[47:40]);
      run_frame(d, wl, off, ws, last, mk_map(int'(v[39:32])),
                d + (wl + 1) * (last + 1) + 4, "R2 R3 R4 R5 R6 frame");
    end

    // R7: sync in the middle of a frame restarts delay and index
    run_frame(3, 1, 4, 1, 19, mk_map(2), 12, "R7 first frame");
    run_frame(3, 1, 4, 1, 19, mk_map(2), 20, "R7 restarted frame");
    run_frame(0, 2, 0, 0, 7, ~'0, 9, "R7 restart zero delay");

    // R5: full map, window end stops enables
    run_frame(2, 0, 5, 0, 12, ~'0, 18, "R5 window end");

    // R1 again: disabling mid-frame returns to pass-through
    run_frame(0, 3, 0, 1, 15, ~'0, 5, "R1 before disable");
    mc_en = 1'b0;
    @(negedge clk);
    check("R1 disable mid-frame", slot_en, ch_busy, ch_idx, 1'b1, 1'b0, 7'd0);

    // R8: reset in the middle of a frame
    mc_en = 1'b1;
    run_frame(0, 3, 0, 1, 15, ~'0, 5, "R8 before reset");
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset mid-frame", slot_en, ch_busy, ch_idx, 1'b0, 1'b0, 7'd0);
    rst = 1'b0;

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected completion earlier", cyc);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule